// File: doc/BRIEF.md
# Optical Drive Command and Response Front End

This block sits between a host CPU and an optical disc drive controller. The host reaches it through a byte-wide register port that is selected by a small offset. Through that port the host loads command parameters, issues command codes, pops response bytes and data bytes, and acknowledges interrupts. Inside are three byte FIFOs: parameter, response and data. A live status byte reports the fill state of each FIFO and whether a command is still running. The data FIFO is filled from the drive side through a simple valid/byte input.

A command sequencer runs four named states. `ST_IDLE` accepts a command write and moves to `ST_DECODE`. `ST_DECODE` checks the code. It moves to `ST_EMIT` for a supported command, or back to `ST_IDLE` with a one-cycle `cmd_unknown` pulse for anything else. `ST_EMIT` pushes one response byte per cycle and moves to `ST_FINISH` after the last byte. `ST_FINISH` writes interrupt code 3 into the flag register, empties the parameter FIFO if the command was a test command, and returns to `ST_IDLE`.

Two commands are supported. The get-status command returns the drive's secondary status byte. The test command with the version subcommand returns a fixed four-byte version string.

Top module: `odc_frontend`

## Requirements
- R1: After reset the status byte reads 0x18, the interrupt flag reads 0, the interrupt enable reads 0x1F and `irq` is low. The secondary status byte holds only its shell-open bit (bit 4), so its value is 0x10.
- R2: The status byte, read at offset 0, is computed live from current state. Bit 7 is busy. Bit 6 is set when the data FIFO is not empty. Bit 5 is set when the response FIFO is not empty. Bit 4 is set when the parameter FIFO has free space. Bit 3 is set when the parameter FIFO is empty. Bits 2..0 always read 0, and bit 2 is the audio-decoder-busy bit.
- R3: A read at offset 1 pops one response byte. A read at offset 2 pops one data byte. The byte appears on `reg_rdata` one cycle after the read strobe. A pop from an empty FIFO returns 0x00.
- R4: Command 0x01 (get status), written at offset 1, pushes the secondary status byte into the response FIFO and writes interrupt code 3 into the flag register.
- R5: Command 0x19 (test), with 0x20 at the head of the parameter FIFO, pushes 0x94, 0x09, 0x19, 0xC0 in that order. It then empties the parameter FIFO and writes interrupt code 3.
- R6: A command write made while busy is ignored. It produces no extra response bytes and does not change the command that is running.
- R7: An unknown command code leaves all FIFOs unchanged, raises no interrupt and pulses `cmd_unknown` for one cycle.
- R8: A test command whose head parameter is not 0x20 leaves the parameter FIFO unchanged, raises no interrupt and pulses `cmd_unknown`.
- R9: A write at offset 2 pushes a parameter byte. The parameter FIFO holds 16 bytes. When it is full, status bit 4 reads 0 and further pushes are dropped.
- R10: `irq` is high exactly while the interrupt flag, read at offset 3, is nonzero. A write at offset 3 clears the flag bits that are written as 1.
- R11: Status bit 7 is set from the cycle after a command is accepted until the sequencer returns to idle.
- R12: A write at offset 4 stores the low 5 bits as the interrupt enable value, which reads back at offset 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offsets 1 and 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request, high while the flag is nonzero |
| drv_valid | input | 1 | Drive-side data byte valid |
| drv_byte | input | 8 | Drive-side data byte into the data FIFO |
| cmd_unknown | output | 1 | One-cycle pulse on an unsupported command or subcommand |

## Verification
The bench writes a second command while the first is still emitting. A sequencer that accepted it would leave extra response bytes, and the bench would see them when it drains the response FIFO to 0x00. It fills the parameter FIFO past 16 bytes with 0x20 at the head. A FIFO that wrapped on overflow would lose that head byte and the version query would fail. A wrong full flag would show in status bit 4. An unknown subcommand must leave its parameter byte in place. A design that popped the byte anyway would flip the parameter-empty bit. Popping empty FIFOs must return 0x00 rather than stale data.

// File: rtl/odc_pkg.sv
package odc_pkg;

    // register offsets
    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_CMD    = 3'd1;   // write: command, read: response pop
    localparam logic [2:0] OFS_PARAM  = 3'd2;   // write: parameter, read: data pop
    localparam logic [2:0] OFS_FLAG   = 3'd3;   // read flag, write-1-to-clear
    localparam logic [2:0] OFS_ENABLE = 3'd4;

    localparam logic [7:0] OP_GETSTAT  = 8'h01;
    localparam logic [7:0] OP_TEST     = 8'h19;
    localparam logic [7:0] SUB_VERSION = 8'h20;

    localparam int         CODE_W      = 3;
    localparam int         FLAG_W      = 5;
    localparam logic [CODE_W-1:0] CODE_ACK = 3'd3;

    typedef struct packed {
        logic playing_audio;
        logic seeking;
        logic reading;
        logic shell_open;
        logic id_fault;
        logic seek_fault;
        logic spindle_on;
        logic fault;
    } drive_stat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_EMIT,
        ST_FINISH
    } seq_state_e;

    function automatic logic [7:0] version_byte(input logic [1:0] i);
        logic [7:0] b;
        unique case (i)
            2'd0: b = 8'h94;
            2'd1: b = 8'h09;
            2'd2: b = 8'h19;
            default: b = 8'hC0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/odc_fifo.sv
module odc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/odc_irq.sv
module odc_irq
    import odc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic [CODE_W-1:0] raise_code,
    input  logic              ack_wr,
    input  logic              en_wr,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flag,
    output logic [FLAG_W-1:0] enable,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= '0;
            enable <= '1;
        end else begin
            if (raise)       flag <= FLAG_W'(raise_code);
            else if (ack_wr) flag <= flag & ~wdata;
            if (en_wr)       enable <= wdata;
        end
    end

    assign irq = |flag;

endmodule

// File: rtl/odc_seq.sv
module odc_seq
    import odc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        param_head,
    input  logic              param_empty,
    input  logic [7:0]        sec_stat,
    output logic              busy,
    output logic [7:0]        held_cmd,
    output logic              resp_push,
    output logic [7:0]        resp_byte,
    output logic              param_clr,
    output logic              raise,
    output logic [CODE_W-1:0] raise_code,
    output logic              cmd_unknown
);
    seq_state_e state, nxt;
    logic [1:0] idx, last;
    logic       is_test, known;

    assign is_test = (held_cmd == OP_TEST);
    assign known   = (held_cmd == OP_GETSTAT) ||
                     (is_test && !param_empty && param_head == SUB_VERSION);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_wr) nxt = ST_DECODE;
            ST_DECODE: nxt = known ? ST_EMIT : ST_IDLE;
            ST_EMIT:   if (idx == last) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // command latch and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cmd <= '0;
            idx      <= '0;
            last     <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (cmd_wr) held_cmd <= cmd_byte;
                ST_DECODE: begin
                    idx  <= '0;
                    last <= is_test ? 2'd3 : 2'd0;
                end
                ST_EMIT:   idx <= idx + 1'b1;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        resp_push   = 1'b0;
        resp_byte   = '0;
        param_clr   = 1'b0;
        raise       = 1'b0;
        raise_code  = '0;
        cmd_unknown = 1'b0;
        unique case (state)
            ST_DECODE: cmd_unknown = !known;
            ST_EMIT: begin
                resp_push = 1'b1;
                resp_byte = is_test ? version_byte(idx) : sec_stat;
            end
            ST_FINISH: begin
                raise      = 1'b1;
                raise_code = CODE_ACK;
                param_clr  = is_test;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/odc_frontend.sv
module odc_frontend
    import odc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       drv_valid,
    input  logic [7:0] drv_byte,
    output logic       cmd_unknown
);
    drive_stat_t       sec_stat;
    logic              busy, resp_push, param_clr, raise;
    logic [7:0]        held_cmd, resp_byte;
    logic [CODE_W-1:0] raise_code;
    logic [FLAG_W-1:0] irq_flag, irq_enable;
    logic [7:0]        param_head, resp_head, data_head, status;
    logic              param_empty, param_full, resp_empty, resp_full;
    logic              data_empty, data_full;
    logic              cmd_wr, param_wr, ack_wr, en_wr, resp_rd, data_rd;

    assign cmd_wr   = reg_wr && reg_addr == OFS_CMD;
    assign param_wr = reg_wr && reg_addr == OFS_PARAM;
    assign ack_wr   = reg_wr && reg_addr == OFS_FLAG;
    assign en_wr    = reg_wr && reg_addr == OFS_ENABLE;
    assign resp_rd  = reg_rd && reg_addr == OFS_CMD;
    assign data_rd  = reg_rd && reg_addr == OFS_PARAM;

    always_ff @(posedge clk) begin
        if (!rst_n) sec_stat <= '{shell_open: 1'b1, default: 1'b0};
        else        sec_stat <= sec_stat;
    end

    odc_seq u_seq (
        .clk, .rst_n, .cmd_wr,
        .cmd_byte   (reg_wdata),
        .param_head, .param_empty,
        .sec_stat   (sec_stat),
        .busy, .held_cmd, .resp_push, .resp_byte, .param_clr,
        .raise, .raise_code, .cmd_unknown
    );

    odc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_param (
        .clk, .rst_n, .clr(param_clr), .push(param_wr), .din(reg_wdata),
        .pop(1'b0), .dout(param_head), .empty(param_empty), .full(param_full)
    );

    odc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_resp (
        .clk, .rst_n, .clr(1'b0), .push(resp_push), .din(resp_byte),
        .pop(resp_rd), .dout(resp_head), .empty(resp_empty), .full(resp_full)
    );

    odc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_data (
        .clk, .rst_n, .clr(1'b0), .push(drv_valid), .din(drv_byte),
        .pop(data_rd), .dout(data_head), .empty(data_empty), .full(data_full)
    );

    odc_irq u_irq (
        .clk, .rst_n, .raise, .raise_code, .ack_wr, .en_wr,
        .wdata (reg_wdata[FLAG_W-1:0]),
        .flag  (irq_flag),
        .enable(irq_enable),
        .irq
    );

    assign status = {busy, !data_empty, !resp_empty, !param_full, param_empty,
                     3'b000};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                OFS_STATUS: reg_rdata <= status;
                OFS_CMD:    reg_rdata <= resp_head;
                OFS_PARAM:  reg_rdata <= data_head;
                OFS_FLAG:   reg_rdata <= {3'b000, irq_flag};
                OFS_ENABLE: reg_rdata <= {3'b000, irq_enable};
                default:    reg_rdata <= {resp_full, data_full, 6'b0};
            endcase
        end
    end

endmodule

// File: rtl/odc_frontend_chk.sv
module odc_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       busy,
    input logic [7:0] held_cmd,
    input logic       irq,
    input logic       raise,
    input logic       resp_push,
    input logic       resp_rd,
    input logic       resp_empty,
    input logic [7:0] reg_rdata
);
    // R6
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(held_cmd));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(raise));

    // R2
    resp_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_push && !resp_rd) |=> !resp_empty);

    // R3
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_rd && resp_empty) |=> (reg_rdata == 8'h00));

endmodule

bind odc_frontend odc_frontend_chk u_chk (
    .clk, .rst_n, .cmd_wr, .busy, .held_cmd, .irq, .raise, .resp_push,
    .resp_rd, .resp_empty, .reg_rdata
);

// File: tb/odc_frontend_tb.sv
module odc_frontend_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, cmd_unknown;
    logic       drv_valid = 1'b0;
    logic [7:0] drv_byte = '0;

    int checks = 0, errors = 0, unk_cnt = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       mon_pending = 1'b0;

    always #4 clk = ~clk;

    odc_frontend u_dut (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
        .irq, .drv_valid, .drv_byte, .cmd_unknown
    );

    always @(posedge clk) begin
        mon_pending <= reg_rd;
        if (cmd_unknown) unk_cnt <= unk_cnt + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_pending && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: read got %02h expected %02h", t, reg_rdata, e);
            end
        end
    end

    function automatic logic [7:0] st(bit b, bit dq, bit rr, bit pr, bit pe);
        return {b, dq, rr, pr, pe, 3'b000};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk(input bit c, input string t, input int act, input int e);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", t, act, e);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int u0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 8'h18, "R1 status");
        rd(3'd3, 8'h00, "R1 flag");
        rd(3'd4, 8'h1F, "R1 enable");
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R12 enable write keeps 5 bits
        wr(3'd4, 8'hE5);
        rd(3'd4, 8'h05, "R12 enable");

        // R4 get status, R11 busy, R6 write while busy
        wr(3'd1, 8'h01);
        rd(3'd0, st(1, 0, 0, 1, 1), "R11 busy bit");
        wr(3'd1, 8'h19);
        settle();
        chk(irq == 1'b1, "R10 irq after get status", irq, 1);
        rd(3'd0, st(0, 0, 1, 1, 1), "R2 response ready");
        rd(3'd3, 8'h03, "R4 flag code");
        rd(3'd1, 8'h10, "R4 secondary status");
        rd(3'd1, 8'h00, "R6 no extra response");
        rd(3'd0, 8'h18, "R2 response drained");

        // R10 acknowledge
        wr(3'd3, 8'h1F);
        chk(irq == 1'b0, "R10 irq after ack", irq, 0);
        rd(3'd3, 8'h00, "R10 flag cleared");

        // R3 data FIFO via drive side
        drv_valid = 1'b1; drv_byte = 8'hA1;
        @(negedge clk);
        drv_byte = 8'hB2;
        @(negedge clk);
        drv_valid = 1'b0;
        rd(3'd0, st(0, 1, 0, 1, 1), "R2 data request");
        rd(3'd2, 8'hA1, "R3 data pop 1");
        rd(3'd2, 8'hB2, "R3 data pop 2");
        rd(3'd2, 8'h00, "R3 empty data pop");
        rd(3'd0, 8'h18, "R2 data drained");

        // R9 fill parameter FIFO past capacity, then R5 version query
        wr(3'd2, 8'h20);
        rd(3'd0, st(0, 0, 0, 1, 0), "R9 param not empty");
        for (int i = 0; i < 16; i++) wr(3'd2, 8'(8'h40 + i));
        rd(3'd0, st(0, 0, 0, 0, 0), "R9 param full");
        wr(3'd1, 8'h19);
        settle();
        rd(3'd1, 8'h94, "R5 byte 0");
        rd(3'd1, 8'h09, "R5 byte 1");
        rd(3'd1, 8'h19, "R5 byte 2");
        rd(3'd1, 8'hC0, "R5 byte 3");
        rd(3'd0, 8'h18, "R5 param cleared");
        rd(3'd3, 8'h03, "R5 flag code");
        wr(3'd3, 8'h07);

        // R8 unknown subcommand
        u0 = unk_cnt;
        wr(3'd2, 8'h33);
        wr(3'd1, 8'h19);
        settle();
        rd(3'd3, 8'h00, "R8 no interrupt");
        rd(3'd0, st(0, 0, 0, 1, 0), "R8 param kept");
        chk(unk_cnt == u0 + 1, "R8 unknown pulse", unk_cnt - u0, 1);
        chk(irq == 1'b0, "R8 irq low", irq, 0);

        // R7 unknown command code
        u0 = unk_cnt;
        wr(3'd1, 8'h05);
        settle();
        chk(unk_cnt == u0 + 1, "R7 unknown pulse", unk_cnt - u0, 1);
        rd(3'd0, st(0, 0, 0, 1, 0), "R7 FIFOs unchanged");
        rd(3'd3, 8'h00, "R7 no interrupt");
        rd(3'd1, 8'h00, "R7 no response");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule